// File: doc/BRIEF.md
# Transmit Descriptor Queue Engine

This block runs the transmit side of a ring-based bus-master network interface. Software places transmit descriptors in a ring of `ENTRIES` slots in memory, then announces them by writing a count to the enqueue input. The count is added to a pending credit. While transmission is enabled and credit remains, the engine reads the next descriptor, passes its buffer address and length to the frame sender, and waits for the sender to report collisions and errors. It then writes a one-word status entry into a parallel status ring and raises the transmit interrupt bit.

Descriptors are handled strictly in ring order. A descriptor that carries the abort flag is never offered to the sender, but it still produces a status entry. The sender MAC and the buffer data DMA are outside the block. Both descriptor and status rings start at a configurable base. Each ring wraps back to its base after the last slot.

Top module: `tx_desc_queue`

## Requirements
- R1: After reset the engine is idle: `rd_req`, `snd_valid`, `st_wr_valid` and `irq_tx` are 0, `pending` is 0 and the first fetch address is `desc_base`.
- R2: Each cycle with `enq_valid` high adds `enq_count` to `pending`, visible on the next cycle.
- R3: While `pending` is 0 or `tx_en` is low, the engine issues no descriptor read (`rd_req` stays 0).
- R4: Descriptor k (counted from reset) is read at `desc_base + 8*(k mod ENTRIES)`. `rd_req` and `rd_addr` hold until `rd_valid`. `rd_data[31:0]` is the buffer address and `rd_data[63:32]` is the control word.
- R5: For a descriptor with control bit 15 (abort) clear, `snd_addr` equals the buffer address and `snd_len` equals control bits 11:0. `snd_valid` holds until `snd_done`. At most one of `rd_req`, `snd_valid`, `st_wr_valid` is high at a time.
- R6: The status word has these fields:
  - bit 31 = 1 (processed);
  - bit 30 = 1 only when no error flag is set and the frame was not aborted;
  - bit 28 = `snd_flags[0]` (carrier lost), bit 26 = `snd_flags[1]` (late collision), bit 25 = `snd_flags[2]` (underrun), bit 24 = `snd_flags[3]` (excessive collisions);
  - bits 20:16 = `snd_ncoll`;
  - bits 14:0 = control bits 30:16 (buffer index);
  - all other bits are 0.
- R7: A descriptor with the abort flag set is not sent. Its status word has bit 29 set, bit 30 clear, and zero flags and collision count.
- R8: The status entry of descriptor k is written at `stat_base + 4*(k mod ENTRIES)`. `st_wr_valid` holds until `st_wr_ready`.
- R9: `irq_tx` becomes 1 the cycle after a status write completes. A cycle with `irq_clr` high clears it, unless a completion happens in that same cycle, in which case it stays 1. Without `irq_clr` it holds its value.
- R10: Each completed status write lowers `pending` by one, combined with any enqueue in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit engine enable |
| desc_base | input | AW | Descriptor ring base address |
| stat_base | input | AW | Status ring base address |
| enq_valid | input | 1 | Enqueue write strobe |
| enq_count | input | CW | Number of descriptors added |
| pending | output | CW | Descriptors waiting or in progress |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | AW | Descriptor read address |
| rd_valid | input | 1 | Descriptor read data valid |
| rd_data | input | 64 | Descriptor: [31:0] buffer address, [63:32] control |
| snd_valid | output | 1 | Frame send request |
| snd_addr | output | 32 | Frame buffer address |
| snd_len | output | 12 | Frame length in bytes |
| snd_done | input | 1 | Send finished, result valid |
| snd_ncoll | input | 5 | Collision count of the frame |
| snd_flags | input | 4 | Error flags: carrier, late coll, underrun, excess coll |
| st_wr_valid | output | 1 | Status write request |
| st_wr_addr | output | AW | Status write address |
| st_wr_data | output | 32 | Status word |
| st_wr_ready | input | 1 | Status write accepted |
| irq_clr | input | 1 | Clear-on-read strobe for the interrupt bit |
| irq_tx | output | 1 | Transmit completion interrupt status |

## Verification
The assertions rely on three properties of the inputs:
- `rd_valid` arrives only while `rd_req` is high;
- `snd_done` arrives only while `snd_valid` is high;
- software never enqueues more descriptors than the ring has slots.

The bench keeps to these rules because it answers each handshake only after it sees the matching request at a falling edge. It holds every response for exactly one cycle. It enqueues in batches that never take `pending` above `ENTRIES`, and only while the engine is idle.

// File: rtl/tdq_pkg.sv
package tdq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_SEND  = 2'd2,
      ST_STAT  = 2'd3
   } tdq_state_e;

   // Send error flag positions
   localparam int FL_CARRIER = 0;
   localparam int FL_LATE    = 1;
   localparam int FL_UNDER   = 2;
   localparam int FL_EXCESS  = 3;

   // Control word field positions
   localparam int CW_ABORT   = 15;

   function automatic logic [31:0] tdq_status(
      input logic        aborted,
      input logic [3:0]  flags,
      input logic [4:0]  ncoll,
      input logic [14:0] bidx);
      logic [31:0] w;
      w        = '0;
      w[31]    = 1'b1;
      w[30]    = ~aborted & ~(|flags);
      w[29]    = aborted;
      w[28]    = flags[FL_CARRIER];
      w[26]    = flags[FL_LATE];
      w[25]    = flags[FL_UNDER];
      w[24]    = flags[FL_EXCESS];
      w[20:16] = ncoll;
      w[14:0]  = bidx;
      return w;
   endfunction

endpackage

// File: rtl/tdq_ring_ptr.sv
module tdq_ring_ptr #(
   parameter int ENTRIES = 8,
   parameter int STRIDE  = 8,
   parameter int AW      = 32,
   localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          advance,
   input  logic [AW-1:0] base,
   output logic [IW-1:0] idx,
   output logic [AW-1:0] addr
);
   localparam logic [AW-1:0] STRIDE_A = AW'(STRIDE);
   localparam bit POW2 = (ENTRIES == (1 << IW));

   logic [IW-1:0] idx_nxt;

   generate
      if (POW2) begin : g_wrap_nat
         assign idx_nxt = idx + 1'b1;
      end else begin : g_wrap_cmp
         assign idx_nxt = (idx == IW'(ENTRIES - 1)) ? '0 : idx + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       idx <= '0;
      else if (advance) idx <= idx_nxt;
   end

   assign addr = base + AW'(idx) * STRIDE_A;

endmodule

// File: rtl/tdq_credit.sv
module tdq_credit #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          add_en,
   input  logic [CW-1:0] add_cnt,
   input  logic          take,
   output logic [CW-1:0] count
);
   logic [CW-1:0] add_v;
   logic [CW-1:0] sub_v;

   assign add_v = add_en ? add_cnt : '0;
   assign sub_v = take ? CW'(1) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) count <= '0;
      else        count <= count + add_v - sub_v;
   end

endmodule

// File: rtl/tdq_engine.sv
module tdq_engine
   import tdq_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_ok,
   output logic        rd_req,
   input  logic        rd_valid,
   input  logic [63:0] rd_data,
   output logic        snd_valid,
   output logic [31:0] snd_addr,
   output logic [11:0] snd_len,
   input  logic        snd_done,
   input  logic [4:0]  snd_ncoll,
   input  logic [3:0]  snd_flags,
   output logic        st_wr_valid,
   output logic [31:0] st_wr_data,
   input  logic        st_wr_ready,
   output logic        done
);
   tdq_state_e  state;
   logic [31:0] buf_q;
   logic [31:0] ctl_q;
   logic [4:0]  ncoll_q;
   logic [3:0]  flags_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         buf_q   <= '0;
         ctl_q   <= '0;
         ncoll_q <= '0;
         flags_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (start_ok) state <= ST_FETCH;
            ST_FETCH: if (rd_valid) begin
               buf_q   <= rd_data[31:0];
               ctl_q   <= rd_data[63:32];
               ncoll_q <= '0;
               flags_q <= '0;
               state   <= rd_data[32 + CW_ABORT] ? ST_STAT : ST_SEND;
            end
            ST_SEND: if (snd_done) begin
               ncoll_q <= snd_ncoll;
               flags_q <= snd_flags;
               state   <= ST_STAT;
            end
            ST_STAT: if (st_wr_ready) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign rd_req      = (state == ST_FETCH);
   assign snd_valid   = (state == ST_SEND);
   assign st_wr_valid = (state == ST_STAT);
   assign snd_addr    = buf_q;
   assign snd_len     = ctl_q[11:0];
   assign st_wr_data  = tdq_status(ctl_q[CW_ABORT], flags_q, ncoll_q, ctl_q[30:16]);
   assign done        = st_wr_valid & st_wr_ready;

endmodule

// File: rtl/tx_desc_queue.sv
module tx_desc_queue #(
   parameter int ENTRIES    = 8,
   parameter int AW         = 32,
   parameter int DESC_BYTES = 8,
   parameter int STAT_BYTES = 4,
   localparam int CW        = $clog2(ENTRIES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tx_en,
   input  logic [AW-1:0] desc_base,
   input  logic [AW-1:0] stat_base,
   input  logic          enq_valid,
   input  logic [CW-1:0] enq_count,
   output logic [CW-1:0] pending,
   output logic          rd_req,
   output logic [AW-1:0] rd_addr,
   input  logic          rd_valid,
   input  logic [63:0]   rd_data,
   output logic          snd_valid,
   output logic [31:0]   snd_addr,
   output logic [11:0]   snd_len,
   input  logic          snd_done,
   input  logic [4:0]    snd_ncoll,
   input  logic [3:0]    snd_flags,
   output logic          st_wr_valid,
   output logic [AW-1:0] st_wr_addr,
   output logic [31:0]   st_wr_data,
   input  logic          st_wr_ready,
   input  logic          irq_clr,
   output logic          irq_tx
);
   localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   initial begin
      if (ENTRIES < 2)    $error("ENTRIES must be at least 2");
      if (AW < 8)         $error("AW too small");
      if (DESC_BYTES < 8) $error("descriptor is two words");
      if (STAT_BYTES < 4) $error("status entry is one word");
   end

   logic          done;
   logic [IW-1:0] d_idx;
   logic [IW-1:0] s_idx;

   tdq_credit #(.CW(CW)) u_credit (
      .clk(clk), .rst_n(rst_n),
      .add_en(enq_valid), .add_cnt(enq_count),
      .take(done), .count(pending)
   );

   tdq_ring_ptr #(.ENTRIES(ENTRIES), .STRIDE(DESC_BYTES), .AW(AW)) u_dptr (
      .clk(clk), .rst_n(rst_n), .advance(done),
      .base(desc_base), .idx(d_idx), .addr(rd_addr)
   );

   tdq_ring_ptr #(.ENTRIES(ENTRIES), .STRIDE(STAT_BYTES), .AW(AW)) u_sptr (
      .clk(clk), .rst_n(rst_n), .advance(done),
      .base(stat_base), .idx(s_idx), .addr(st_wr_addr)
   );

   tdq_engine u_eng (
      .clk(clk), .rst_n(rst_n),
      .start_ok(tx_en && (pending != '0)),
      .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
      .snd_valid(snd_valid), .snd_addr(snd_addr), .snd_len(snd_len),
      .snd_done(snd_done), .snd_ncoll(snd_ncoll), .snd_flags(snd_flags),
      .st_wr_valid(st_wr_valid), .st_wr_data(st_wr_data),
      .st_wr_ready(st_wr_ready), .done(done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       irq_tx <= 1'b0;
      else if (done)    irq_tx <= 1'b1;
      else if (irq_clr) irq_tx <= 1'b0;
   end

endmodule

// File: rtl/tx_desc_queue_chk.sv
module tx_desc_queue_chk #(
   parameter int ENTRIES = 8,
   parameter int AW      = 32,
   parameter int CW      = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          enq_valid,
   input logic [CW-1:0] pending,
   input logic          rd_req,
   input logic [AW-1:0] rd_addr,
   input logic          rd_valid,
   input logic          snd_valid,
   input logic          st_wr_valid,
   input logic [31:0]   st_wr_data,
   input logic          st_wr_ready,
   input logic          irq_tx
);
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pending <= CW'(ENTRIES)); // R2

   AST_NO_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (pending == '0) |-> !rd_req); // R3

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr))); // R4

   AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_req, snd_valid, st_wr_valid})); // R5

   AST_STAT_PROCESSED: assert property (@(posedge clk) disable iff (!rst_n)
      st_wr_valid |-> st_wr_data[31]); // R6

   AST_ABORT_NOT_OK: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr_valid && st_wr_data[29]) |-> !st_wr_data[30]); // R7

   AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr_valid && st_wr_ready) |=> irq_tx); // R9

   AST_PEND_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr_valid && st_wr_ready && !enq_valid) |=>
      (pending == $past(pending) - CW'(1))); // R10

endmodule

bind tx_desc_queue tx_desc_queue_chk #(.ENTRIES(ENTRIES), .AW(AW), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .pending(pending),
   .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
   .snd_valid(snd_valid), .st_wr_valid(st_wr_valid), .st_wr_data(st_wr_data),
   .st_wr_ready(st_wr_ready), .irq_tx(irq_tx)
);

// File: tb/tb_tx_desc_queue.sv
module tb_tx_desc_queue;
   localparam int ENTRIES = 8;
   localparam int AW      = 32;
   localparam int CW      = $clog2(ENTRIES + 1);
   localparam logic [31:0] DBASE = 32'h0000_4000;
   localparam logic [31:0] SBASE = 32'h0000_8000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tx_en = 1'b0;
   logic          enq_valid = 1'b0;
   logic [CW-1:0] enq_count = '0;
   logic [CW-1:0] pending;
   logic          rd_req;
   logic [AW-1:0] rd_addr;
   logic          rd_valid = 1'b0;
   logic [63:0]   rd_data = '0;
   logic          snd_valid;
   logic [31:0]   snd_addr;
   logic [11:0]   snd_len;
   logic          snd_done = 1'b0;
   logic [4:0]    snd_ncoll = '0;
   logic [3:0]    snd_flags = '0;
   logic          st_wr_valid;
   logic [AW-1:0] st_wr_addr;
   logic [31:0]   st_wr_data;
   logic          st_wr_ready = 1'b0;
   logic          irq_clr = 1'b0;
   logic          irq_tx;

   int total = 0;
   int bad   = 0;
   int k     = 0;
   int cyc   = 0;

   always #10 clk = ~clk;

   tx_desc_queue #(.ENTRIES(ENTRIES), .AW(AW)) dut (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
      .desc_base(DBASE), .stat_base(SBASE),
      .enq_valid(enq_valid), .enq_count(enq_count), .pending(pending),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
      .snd_valid(snd_valid), .snd_addr(snd_addr), .snd_len(snd_len),
      .snd_done(snd_done), .snd_ncoll(snd_ncoll), .snd_flags(snd_flags),
      .st_wr_valid(st_wr_valid), .st_wr_addr(st_wr_addr), .st_wr_data(st_wr_data),
      .st_wr_ready(st_wr_ready), .irq_clr(irq_clr), .irq_tx(irq_tx)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         finish_run();
      end
   end

   // Wait (at falling edges) for a request line; 0=rd,1=snd,2=stat
   task automatic wait_req(input int which, input string req);
      int n = 0;
      forever begin
         @(negedge clk);
         if ((which == 0 && rd_req) || (which == 1 && snd_valid) ||
             (which == 2 && st_wr_valid)) break;
         n++;
         if (n > 200) begin
            chk(req, 64'd0, 64'd1);
            break;
         end
      end
   endtask

   function automatic logic abort_of(input int n);
      return (n % 5) == 3;
   endfunction
   function automatic logic [14:0] bidx_of(input int n);
      return 15'((n * 3 + 1) & 16'h7fff);
   endfunction
   function automatic logic [11:0] len_of(input int n);
      return 12'((n * 37 + 60) & 12'hfff);
   endfunction

   task automatic enqueue(input int cnt);
      @(negedge clk);
      enq_valid = 1'b1;
      enq_count = CW'(cnt);
      @(negedge clk);
      enq_valid = 1'b0;
      enq_count = '0;
   endtask

   // Serve descriptor number n through all three phases
   task automatic serve(input int n, input logic clr_at_done);
      logic [31:0] bufa;
      logic [31:0] ctl;
      logic [3:0]  fl;
      logic [4:0]  nc;
      logic [31:0] expw;
      int          slot;
      logic [CW-1:0] pend_before;
      slot = n % ENTRIES;
      bufa = 32'h1000_0000 + 32'(n) * 32'h800;
      ctl  = {1'b1, bidx_of(n), abort_of(n), 3'b000, len_of(n)};
      fl   = 4'(n % 16);
      nc   = 5'((n * 7) % 32);
      wait_req(0, "R4");
      chk("R4", 64'(rd_addr), 64'(DBASE + 32'(slot * 8)));
      rd_valid = 1'b1;
      rd_data  = {ctl, bufa};
      @(negedge clk);
      rd_valid = 1'b0;
      if (!abort_of(n)) begin
         wait_req(1, "R5");
         chk("R5", {20'd0, snd_len, snd_addr}, {20'd0, len_of(n), bufa});
         snd_done  = 1'b1;
         snd_ncoll = nc;
         snd_flags = fl;
         @(negedge clk);
         snd_done  = 1'b0;
         snd_ncoll = '0;
         snd_flags = '0;
         expw = 32'h8000_0000;
         expw[30]    = (fl == 4'd0);
         expw[28]    = fl[0];
         expw[26]    = fl[1];
         expw[25]    = fl[2];
         expw[24]    = fl[3];
         expw[20:16] = nc;
         expw[14:0]  = bidx_of(n);
         wait_req(2, "R6");
         chk("R6", 64'(st_wr_data), 64'(expw));
      end else begin
         wait_req(2, "R7");
         chk("R7", 64'(snd_valid), 64'd0);
         chk("R7", 64'(st_wr_data), 64'(32'hA000_0000 | 32'(bidx_of(n))));
      end
      chk("R8", 64'(st_wr_addr), 64'(SBASE + 32'(slot * 4)));
      pend_before = pending;
      st_wr_ready = 1'b1;
      irq_clr     = clr_at_done;
      @(negedge clk);
      st_wr_ready = 1'b0;
      irq_clr     = 1'b0;
      chk("R9", 64'(irq_tx), 64'd1);
      chk("R10", 64'(pending), 64'(pend_before - CW'(1)));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", {60'd0, rd_req, snd_valid, st_wr_valid, irq_tx}, 64'd0);
      chk("R1", 64'(pending), 64'd0);
      chk("R1", 64'(rd_addr), 64'(DBASE));

      // R3: enabled but no credit -> no reads
      tx_en = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (rd_req) chk("R3", 64'(rd_req), 64'd0);
      end
      chk("R3", 64'(rd_req), 64'd0);

      // R3 with credit but disabled; R2 add
      tx_en = 1'b0;
      enqueue(3);
      chk("R2", 64'(pending), 64'd3);
      enqueue(2);
      chk("R2", 64'(pending), 64'd5);
      for (int i = 0; i < 10; i++) @(negedge clk);
      chk("R3", 64'(rd_req), 64'd0);
      tx_en = 1'b1;

      for (int i = 0; i < 5; i++) begin
         serve(k, 1'b0);
         k++;
      end
      chk("R10", 64'(pending), 64'd0);

      // R9 preserving: holds without clear
      repeat (4) @(negedge clk);
      chk("R9", 64'(irq_tx), 64'd1);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      chk("R9", 64'(irq_tx), 64'd0);

      // Sweep several batch sizes across ring wraps; last item of each
      // batch completes with a simultaneous clear (set wins)
      for (int b = 1; b <= ENTRIES; b++) begin
         enqueue(b);
         chk("R2", 64'(pending), 64'(b));
         for (int j = 0; j < b; j++) begin
            serve(k, (j == b - 1));
            k++;
         end
         irq_clr = 1'b1;
         @(negedge clk);
         irq_clr = 1'b0;
         chk("R9", 64'(irq_tx), 64'd0);
         repeat (3) @(negedge clk);
         chk("R3", 64'(rd_req), 64'd0);
      end

      finish_run();
   end

endmodule